// File: doc/BRIEF.md
# Instruction-Keyed Stride Prefetcher

This block watches a stream of load operations, each carrying the instruction pointer of the load and the data address it touched. A small direct-mapped history table, indexed by low bits of the instruction pointer, remembers the last address and last stride seen for each load instruction. It also keeps a two-bit confidence count. Once the same instruction has stepped by the same non-zero distance often enough, the block predicts the next address, rounds it down to a 64-byte line and places it in a short pending queue.

The head of the queue is offered to the cache through a presence probe, but only in a cycle when the lower-level bus is idle. A line that is already cached is dropped. A line that is not cached becomes a one-cycle prefetch request on the bus. Data returning from the bus is written into a separate prefetch buffer, never into the cache. Responses flagged as faulty, such as a bad page, are discarded without any signal.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, pf_req_valid, probe_valid and buf_wr_en are all 0.
- R2: The table has 16 entries selected by ld_ip[3:0], and the remaining IP bits form the tag. A load whose IP maps to an occupied entry with a different tag takes over that entry with confidence 0. The evicted instruction then needs four fresh loads before it predicts again.
- R3: On a tag hit the stride is ld_addr minus the stored address. Confidence goes up by one, saturating at 3, when the stride equals the stored stride. A prediction of (ld_addr + stride) rounded down to a 64-byte line is made when the updated confidence is at least 2 and the stride is non-zero. In a constant-stride stream, the fourth and every later load predict.
- R4: A stride that differs from the stored one resets confidence to 0. Two more loads at the new stride are then needed before the following load predicts.
- R5: A stream whose stride is zero never produces a prediction.
- R6: probe_valid is 1 only when the queue holds an entry and bus_busy is 0, with probe_line equal to the oldest entry. If cache_hit is 1 in that cycle, the entry is removed and no request is made.
- R7: When the head is probed with cache_hit 0, pf_req_valid is 1 for one cycle after that edge, with pf_req_addr equal to the line. Nothing is probed or requested while bus_busy is 1. A prediction made on a load reaches pf_req_valid three clock edges after the load is captured.
- R8: The queue holds 4 lines, issued oldest first. A new line arriving when the queue is full evicts the oldest entry.
- R9: A predicted line equal to one already held in the queue is not added.
- R10: A response with rsp_valid 1 and rsp_err 0 appears on buf_wr_en, buf_wr_addr and buf_wr_data one cycle later.
- R11: A response with rsp_err 1 produces no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is observed this cycle |
| ld_ip | input | IP_W | Instruction pointer of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| bus_busy | input | 1 | Lower-level bus is in use this cycle |
| probe_valid | output | 1 | Cache presence probe is active |
| probe_line | output | ADDR_W | Line address being probed |
| cache_hit | input | 1 | Probed line is present in the cache |
| pf_req_valid | output | 1 | Prefetch request pulse to the bus |
| pf_req_addr | output | ADDR_W | Line address of the prefetch request |
| rsp_valid | input | 1 | Prefetch data returns from the bus |
| rsp_err | input | 1 | Returned prefetch faulted |
| rsp_addr | input | ADDR_W | Line address of the returned data |
| rsp_data | input | DATA_W | Returned data |
| buf_wr_en | output | 1 | Write into the prefetch buffer |
| buf_wr_addr | output | ADDR_W | Line address written to the buffer |
| buf_wr_data | output | DATA_W | Data written to the buffer |

## Verification
The hardest state to reach from the ports is a full queue that must evict its oldest line, or that must refuse a repeated line. The queue normally drains one line per idle cycle, so it barely fills. The bench holds bus_busy high while it trains one instruction far enough to produce six predictions. It then releases the bus and checks the exact order of the four surviving requests. A stride of 16 under the same hold makes four predictions fall into one line, which exercises the duplicate filter.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MAX   = 2'd3;
  localparam conf_t CONF_ISSUE = 2'd2;

  function automatic conf_t conf_bump(input conf_t c);
    return (c == CONF_MAX) ? c : c + 2'd1;
  endfunction
endpackage

// File: rtl/pf_history_table.sv
module pf_history_table
  import pf_pkg::*;
#(
  parameter int IP_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_line
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = IP_W - IDX_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

  // storage without reset so it maps onto distributed RAM
  logic [TAG_W-1:0]  tag_mem    [ENTRIES];
  logic [ADDR_W-1:0] addr_mem   [ENTRIES];
  logic [ADDR_W-1:0] stride_mem [ENTRIES];
  conf_t             conf_mem   [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, same;
  logic [ADDR_W-1:0] new_stride, stride_nxt;
  conf_t             conf_nxt;

  always_comb begin
    idx        = ld_ip[IDX_W-1:0];
    tag        = ld_ip[IP_W-1:IDX_W];
    hit        = valid_q[idx] && (tag_mem[idx] == tag);
    new_stride = ld_addr - addr_mem[idx];
    same       = (new_stride == stride_mem[idx]);
    conf_nxt   = '0;
    stride_nxt = '0;
    if (hit) begin
      stride_nxt = new_stride;
      conf_nxt   = same ? conf_bump(conf_mem[idx]) : conf_t'(0);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      tag_mem[idx]    <= tag;
      addr_mem[idx]   <= ld_addr;
      stride_mem[idx] <= stride_nxt;
      conf_mem[idx]   <= conf_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      pred_valid <= 1'b0;
      pred_line  <= '0;
    end else begin
      if (ld_valid) valid_q[idx] <= 1'b1;
      pred_valid <= ld_valid && hit && same && (conf_nxt >= CONF_ISSUE)
                    && (new_stride != '0);
      pred_line  <= (ld_addr + new_stride) & LINE_MASK;
    end
  end
endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_line,
  input  logic              pop,
  output logic              head_valid,
  output logic [ADDR_W-1:0] head_line
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] line_q [DEPTH];
  logic [ADDR_W-1:0] line_d [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dup;

  assign head_valid = (cnt_q != '0);
  assign head_line  = line_q[0];

  always_comb begin
    int n;
    n   = int'(cnt_q);
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      line_d[i] = line_q[i];
      if (i < n && line_q[i] == push_line) dup = 1'b1;
    end
    if (pop && n > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) line_d[i] = line_d[i+1];
      n = n - 1;
    end
    if (push && !dup) begin
      if (n == DEPTH) begin
        for (int i = 0; i < DEPTH - 1; i++) line_d[i] = line_d[i+1];
        n = n - 1;
      end
      line_d[n] = push_line;
      n = n + 1;
    end
    cnt_d = CNT_W'(n);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int IP_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int ENTRIES    = 16,
  parameter int QDEPTH     = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              bus_busy,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_line,
  input  logic              cache_hit,
  output logic              pf_req_valid,
  output logic [ADDR_W-1:0] pf_req_addr,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              buf_wr_en,
  output logic [ADDR_W-1:0] buf_wr_addr,
  output logic [DATA_W-1:0] buf_wr_data
);
  logic              pred_valid;
  logic [ADDR_W-1:0] pred_line;
  logic              head_valid;
  logic [ADDR_W-1:0] head_line;
  logic              take;

  pf_history_table #(
    .IP_W(IP_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LINE_BYTES(LINE_BYTES)
  ) u_table (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ip(ld_ip),
    .ld_addr(ld_addr), .pred_valid(pred_valid), .pred_line(pred_line)
  );

  pf_queue #(.ADDR_W(ADDR_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(pred_valid), .push_line(pred_line),
    .pop(take), .head_valid(head_valid), .head_line(head_line)
  );

  // the head leaves the queue in every idle-bus cycle: as a request or dropped
  assign take        = head_valid && !bus_busy;
  assign probe_valid = take;
  assign probe_line  = head_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_req_valid <= 1'b0;
      pf_req_addr  <= '0;
      buf_wr_en    <= 1'b0;
      buf_wr_addr  <= '0;
      buf_wr_data  <= '0;
    end else begin
      pf_req_valid <= take && !cache_hit;
      if (take) pf_req_addr <= head_line;
      // faulted prefetches vanish here without any report
      buf_wr_en <= rsp_valid && !rsp_err;
      if (rsp_valid) begin
        buf_wr_addr <= rsp_addr;
        buf_wr_data <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_busy,
  input logic              probe_valid,
  input logic              cache_hit,
  input logic              pf_req_valid,
  input logic [ADDR_W-1:0] pf_req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              buf_wr_en
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R7
  req_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    pf_req_valid |-> $past(!bus_busy));

  // R7
  req_follows_probe_chk: assert property (@(posedge clk) disable iff (rst)
    pf_req_valid |-> $past(probe_valid && !cache_hit));

  // R6
  cached_line_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (probe_valid && cache_hit) |=> !pf_req_valid);

  // R3
  req_line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pf_req_valid |-> (pf_req_addr[OFF_W-1:0] == '0));

  // R10
  buf_write_source_chk: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> $past(rsp_valid && !rsp_err));

  // R11
  fault_discarded_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |=> !buf_wr_en);
endmodule

bind stride_prefetcher pf_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst(rst), .bus_busy(bus_busy), .probe_valid(probe_valid),
  .cache_hit(cache_hit), .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .buf_wr_en(buf_wr_en)
);

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;
  logic        clk = 0;
  logic        rst = 1;
  logic        ld_valid = 0;
  logic [31:0] ld_ip = 0, ld_addr = 0;
  logic        bus_busy = 0, cache_hit = 0;
  logic        probe_valid, pf_req_valid, buf_wr_en;
  logic [31:0] probe_line, pf_req_addr, buf_wr_addr;
  logic        rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_addr = 0;
  logic [63:0] rsp_data = 0, buf_wr_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stride_prefetcher dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ip(ld_ip), .ld_addr(ld_addr),
    .bus_busy(bus_busy), .probe_valid(probe_valid), .probe_line(probe_line),
    .cache_hit(cache_hit), .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] line_of(input logic [31:0] a);
    return a & ~32'h3F;
  endfunction

  // one load, captured at the next edge; returns at the negedge after it
  task automatic do_load(input logic [31:0] ip, input logic [31:0] addr);
    @(negedge clk);
    ld_valid = 1; ld_ip = ip; ld_addr = addr;
    @(negedge clk);
    ld_valid = 0;
  endtask

  // load, then look at the request three edges after capture
  task automatic load_and_check(input logic [31:0] ip, input logic [31:0] addr,
                                input bit exp_v, input logic [31:0] exp_a,
                                input string req);
    do_load(ip, addr);
    @(negedge clk);
    @(negedge clk);
    chk(pf_req_valid == exp_v, req, "pf_req_valid", 64'(pf_req_valid), 64'(exp_v));
    if (exp_v) chk(pf_req_addr == exp_a, req, "pf_req_addr", 64'(pf_req_addr), 64'(exp_a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!pf_req_valid, "R1", "pf_req_valid", 64'(pf_req_valid), 0);
    chk(!probe_valid, "R1", "probe_valid", 64'(probe_valid), 0);
    chk(!buf_wr_en, "R1", "buf_wr_en", 64'(buf_wr_en), 0);

    // R3 stride sweep: load k at base+(k-1)s predicts base+k*s from k=4
    begin
      int strides [7] = '{64, 128, -64, 32, 192, 4096, -200};
      for (int si = 0; si < 7; si++) begin
        logic [31:0] base;
        base = 32'h0010_0000 + 32'(si) * 32'h1_0000 + 32'h24;
        for (int k = 1; k <= 6; k++) begin
          load_and_check(32'h0000_1000 + 32'(si), base + 32'((k-1) * strides[si]),
                         k >= 4, line_of(base + 32'(k * strides[si])), "R3");
        end
      end
    end

    // R5 zero stride never predicts
    for (int k = 1; k <= 6; k++)
      load_and_check(32'h0000_2008, 32'h0030_0040, 0, 0, "R5");

    // R4 stride change: 4 loads at +64, then +128 steps
    begin
      logic [31:0] a;
      a = 32'h0040_0000;
      for (int k = 1; k <= 4; k++)
        load_and_check(32'h0000_300A, a + 32'((k-1)*64), k == 4, line_of(a + 32'(k*64)), "R4");
      a = a + 32'd192;
      load_and_check(32'h0000_300A, a + 32'd128, 0, 0, "R4");
      load_and_check(32'h0000_300A, a + 32'd256, 0, 0, "R4");
      load_and_check(32'h0000_300A, a + 32'd384, 1, line_of(a + 32'd512), "R4");
    end

    // R2 aliasing IP with same index evicts the entry
    begin
      logic [31:0] a;
      a = 32'h0050_0000;
      for (int k = 1; k <= 4; k++)
        load_and_check(32'h0000_4100, a + 32'((k-1)*256), k == 4, line_of(a + 32'(k*256)), "R2");
      load_and_check(32'h0000_5100, 32'h0060_0000, 0, 0, "R2");
      for (int k = 5; k <= 8; k++)
        load_and_check(32'h0000_4100, a + 32'((k-1)*256), k == 8, line_of(a + 32'(k*256)), "R2");
    end

    // R6 cached line probed then dropped
    begin
      logic [31:0] a;
      a = 32'h0070_0000;
      cache_hit = 1;
      for (int k = 1; k <= 3; k++) load_and_check(32'h0000_600C, a + 32'((k-1)*64), 0, 0, "R6");
      do_load(32'h0000_600C, a + 32'd192);
      @(negedge clk);
      chk(probe_valid, "R6", "probe_valid", 64'(probe_valid), 1);
      chk(probe_line == a + 32'd256, "R6", "probe_line", 64'(probe_line), 64'(a + 32'd256));
      @(negedge clk);
      chk(!pf_req_valid, "R6", "pf_req_valid on hit", 64'(pf_req_valid), 0);
      chk(!probe_valid, "R6", "probe_valid after drop", 64'(probe_valid), 0);
      cache_hit = 0;
      repeat (3) @(negedge clk);
      chk(!pf_req_valid, "R6", "no late request", 64'(pf_req_valid), 0);
    end

    // R7 bus busy blocks probe and request
    begin
      logic [31:0] a;
      a = 32'h0080_0000;
      bus_busy = 1;
      for (int k = 1; k <= 4; k++) load_and_check(32'h0000_700D, a + 32'((k-1)*128), 0, 0, "R7");
      repeat (5) @(negedge clk);
      chk(!probe_valid, "R7", "probe_valid busy", 64'(probe_valid), 0);
      chk(!pf_req_valid, "R7", "pf_req_valid busy", 64'(pf_req_valid), 0);
      bus_busy = 0;
      @(negedge clk);
      chk(pf_req_valid, "R7", "pf_req_valid after release", 64'(pf_req_valid), 1);
      chk(pf_req_addr == a + 32'd512, "R7", "pf_req_addr", 64'(pf_req_addr), 64'(a + 32'd512));
      @(negedge clk);
      chk(!pf_req_valid, "R7", "single pulse", 64'(pf_req_valid), 0);
    end

    // R8 overflow: 6 predictions, last 4 survive in order
    begin
      logic [31:0] a;
      a = 32'h0090_0000;
      bus_busy = 1;
      for (int k = 1; k <= 9; k++) load_and_check(32'h0000_800E, a + 32'((k-1)*64), 0, 0, "R8");
      bus_busy = 0;
      for (int k = 6; k <= 9; k++) begin
        @(negedge clk);
        chk(pf_req_valid, "R8", "pf_req_valid", 64'(pf_req_valid), 1);
        chk(pf_req_addr == a + 32'(k*64), "R8", "pf_req_addr", 64'(pf_req_addr), 64'(a + 32'(k*64)));
      end
      @(negedge clk);
      chk(!pf_req_valid, "R8", "queue empty", 64'(pf_req_valid), 0);
    end

    // R9 duplicates: stride 16 puts four predictions in one line
    begin
      logic [31:0] a;
      a = 32'h00A0_0000;
      bus_busy = 1;
      for (int k = 1; k <= 8; k++) load_and_check(32'h0000_900F, a + 32'((k-1)*16), 0, 0, "R9");
      bus_busy = 0;
      @(negedge clk);
      chk(pf_req_valid && pf_req_addr == a + 32'd64, "R9", "first line",
          64'(pf_req_addr), 64'(a + 32'd64));
      @(negedge clk);
      chk(pf_req_valid && pf_req_addr == a + 32'd128, "R9", "second line",
          64'(pf_req_addr), 64'(a + 32'd128));
      @(negedge clk);
      chk(!pf_req_valid, "R9", "no duplicate", 64'(pf_req_valid), 0);
    end

    // R10 / R11 responses to the prefetch buffer
    for (int i = 0; i < 6; i++) begin
      bit e;
      e = (i % 2) == 1;
      @(negedge clk);
      rsp_valid = 1; rsp_err = e;
      rsp_addr = 32'h00B0_0000 + 32'(i * 64);
      rsp_data = 64'hA5A5_0000_0000_0000 + 64'(i);
      @(negedge clk);
      rsp_valid = 0; rsp_err = 0;
      if (e) chk(!buf_wr_en, "R11", "buf_wr_en on fault", 64'(buf_wr_en), 0);
      else begin
        chk(buf_wr_en, "R10", "buf_wr_en", 64'(buf_wr_en), 1);
        chk(buf_wr_addr == 32'h00B0_0000 + 32'(i * 64), "R10", "buf_wr_addr",
            64'(buf_wr_addr), 64'(32'h00B0_0000 + 32'(i * 64)));
        chk(buf_wr_data == 64'hA5A5_0000_0000_0000 + 64'(i), "R10", "buf_wr_data",
            buf_wr_data, 64'hA5A5_0000_0000_0000 + 64'(i));
      end
    end
    @(negedge clk);
    chk(!buf_wr_en, "R10", "idle buf_wr_en", 64'(buf_wr_en), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule